// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This block performs 32-bit integer multiplication and division next to a processor datapath. Its results go to a dedicated 64-bit result pair: an upper word `hi` and a lower word `lo`. A multiply takes the whole 64-bit product of two operands. A multiply-accumulate adds that product to the current contents of the pair. Some variants also return the new lower word on a write-back port, so the result can reach a general register. Division produces a quotient and a remainder.

An operation is requested by holding `start` high for one clock, with an operation code and two operands. Multiplies complete in the clock edge that accepts them. A division with a non-zero divisor runs a bit-serial loop, and `busy` stays high while it runs. Every operation that is accepted ends with a single-cycle `done` pulse. A division by zero does not write a result. Instead it raises an exception flag.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `hi`, `lo`, `busy`, `done`, `wb_valid`, `wb_data` and `div_zero` are all zero.
- R2: The operation code has bit 3 low for a multiply. Bit 0 selects unsigned (1) or signed (0) operands. A plain multiply (bits 2 and 1 clear) writes the 64-bit product of the extended operands with its upper half to `hi` and its lower half to `lo`. `done` is high in the cycle after the accepting edge.
- R3: A multiply with bit 2 set adds the 64-bit product to the previous {`hi`,`lo`} and writes the 64-bit sum back, wrapping modulo 2^64.
- R4: A multiply with bit 1 set raises `wb_valid` together with `done` and presents the new `lo` on `wb_data`. Every other operation completes with `wb_valid` low.
- R5: Bit 3 high selects a divide, and bit 0 selects unsigned (1) or signed (0). With a non-zero divisor, `busy` is high for exactly 32 cycles after the accepting edge. `done` then pulses in the cycle `busy` falls, with the quotient in `lo` and the remainder in `hi`.
- R6: Signed division truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R7: Signed 0x80000000 divided by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0, and `div_zero` stays low.
- R8: A divide by zero completes with `done` in the next cycle without raising `busy`. It leaves `hi` and `lo` unchanged and sets `div_zero`. Any later completed operation clears `div_zero`.
- R9: `start` is ignored while `busy` is high. It causes no extra `done` and does not change `hi` or `lo`.
- R10: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation this cycle |
| op | input | 4 | Operation code: [3] divide, [2] accumulate, [1] write back, [0] unsigned |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Division loop in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper result word / remainder |
| lo | output | 32 | Lower result word / quotient |
| wb_valid | output | 1 | Write-back result valid with `done` |
| wb_data | output | 32 | New `lo` for write-back variants |
| div_zero | output | 1 | Divide-by-zero exception flag |

## Verification
A corrupted partial remainder or quotient shift register stays hidden until the division ends. It then appears at once as a wrong `lo`/`hi` pair on the `done` cycle, 32 cycles after the request. A miscounted iteration counter shows up sooner, as a `busy` window that is not exactly 32 cycles long. An error in the accumulator path persists in `hi`/`lo`, so it corrupts every later accumulate as well. The bench therefore chains accumulates and compares the pair at every completion.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         wb_valid,
  output logic [W-1:0] wb_data,
  output logic         div_zero
);
  localparam int CW = $clog2(W);
  localparam int PW = 2 * W;

  logic is_div, uns, acc, ret;
  assign is_div = op[3];
  assign acc    = op[2];
  assign ret    = op[1];
  assign uns    = op[0];

  logic [PW-1:0] ext_a, ext_b, prod, mac_sum;
  assign ext_a   = {{W{~uns & src_a[W-1]}}, src_a};
  assign ext_b   = {{W{~uns & src_b[W-1]}}, src_b};
  assign prod    = ext_a * ext_b;
  assign mac_sum = (acc ? {hi, lo} : '0) + prod;

  logic         a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;
  assign a_neg = ~uns & src_a[W-1];
  assign b_neg = ~uns & src_b[W-1];
  assign mag_a = a_neg ? -src_a : src_a;
  assign mag_b = b_neg ? -src_b : src_b;

  logic [W-1:0]  quo, rem, dvs;
  logic [CW-1:0] cnt;
  logic          neg_q, neg_r;

  logic [W:0]   shifted, diff;
  logic         ge;
  logic [W-1:0] rem_n, quo_n, fin_q, fin_r;
  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, dvs};
  assign ge      = ~diff[W];
  assign rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo[W-2:0], ge};
  assign fin_q   = neg_q ? -quo_n : quo_n;
  assign fin_r   = neg_r ? -rem_n : rem_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      hi       <= '0;
      lo       <= '0;
      wb_valid <= 1'b0;
      wb_data  <= '0;
      div_zero <= 1'b0;
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      cnt      <= '0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      if (busy) begin
        quo <= quo_n;
        rem <= rem_n;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          lo       <= fin_q;
          hi       <= fin_r;
          div_zero <= 1'b0;
        end
      end else if (start) begin
        if (!is_div) begin
          hi       <= mac_sum[PW-1:W];
          lo       <= mac_sum[W-1:0];
          done     <= 1'b1;
          wb_valid <= ret;
          wb_data  <= mac_sum[W-1:0];
          div_zero <= 1'b0;
        end else if (src_b == '0) begin
          done     <= 1'b1;
          div_zero <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cnt   <= '0;
          rem   <= '0;
          quo   <= mag_a;
          dvs   <= mag_b;
          neg_q <= a_neg ^ b_neg;
          neg_r <= a_neg;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         wb_valid,
  input logic         div_zero
);
  localparam int BW = $clog2(W) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  p_wb_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < BW'(W));
  p_end_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));
  p_zero_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .hi(hi), .lo(lo), .wb_valid(wb_valid), .div_zero(div_zero));

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam logic [3:0] OP_MUL = 4'b0000, OP_MULU = 4'b0001, OP_MULR = 4'b0010,
    OP_MULRU = 4'b0011, OP_MAC = 4'b0100, OP_MACU = 4'b0101, OP_MACR = 4'b0110,
    OP_MACRU = 4'b0111, OP_DIV = 4'b1000, OP_DIVU = 4'b1001;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic busy, done, wb_valid, div_zero;
  logic [31:0] hi, lo, wb_data;

  muldiv_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a),
    .src_b(src_b), .busy(busy), .done(done), .hi(hi), .lo(lo), .wb_valid(wb_valid),
    .wb_data(wb_data), .div_zero(div_zero));

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] hi, lo, wb;
    logic        wbv, z;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(hi == e.hi, e.tag, "hi", 64'(hi), 64'(e.hi));
        chk(lo == e.lo, e.tag, "lo", 64'(lo), 64'(e.lo));
        chk(wb_valid == e.wbv, {e.tag, "/R4"}, "wb_valid", 64'(wb_valid), 64'(e.wbv));
        if (e.wbv) chk(wb_data == e.wb, {e.tag, "/R4"}, "wb_data", 64'(wb_data), 64'(e.wb));
        chk(div_zero == e.z, {e.tag, "/R8"}, "div_zero", 64'(div_zero), 64'(e.z));
      end
    end
  end

  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input string tag, input bit inject);
    exp_t e;
    logic [63:0] p;
    longint qs, rs;
    int bcount;
    e.tag = tag; e.z = 1'b0; e.wbv = 1'b0; e.wb = '0;
    if (!o[3]) begin
      if (o[0]) p = {32'd0, a} * {32'd0, b};
      else      p = 64'(longint'($signed(a)) * longint'($signed(b)));
      if (o[2]) p = p + {m_hi, m_lo};
      m_hi = p[63:32]; m_lo = p[31:0];
      e.wbv = o[1]; e.wb = p[31:0];
    end else if (b == 0) begin
      e.z = 1'b1;
    end else if (o[0]) begin
      m_lo = a / b; m_hi = a % b;
    end else begin
      qs = longint'($signed(a)) / longint'($signed(b));
      rs = longint'($signed(a)) % longint'($signed(b));
      m_lo = qs[31:0]; m_hi = rs[31:0];
    end
    e.hi = m_hi; e.lo = m_lo;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    bcount = 0;
    while (!done) begin
      if (busy) bcount++;
      if (inject && bcount == 5) begin
        start = 1'b1; op = OP_MUL; src_a = 32'd7; src_b = 32'd9;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(bcount == ((o[3] && b != 0) ? 32 : 0), "R5", "busy cycles",
        64'(bcount), (o[3] && b != 0) ? 64'd32 : 64'd0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hi, lo} == 64'd0, "R1", "hi:lo after reset", {hi, lo}, 64'd0);
    chk({busy, done, wb_valid, div_zero} == 4'd0, "R1", "flags after reset",
        64'({busy, done, wb_valid, div_zero}), 64'd0);
    chk(wb_data == 32'd0, "R1", "wb_data after reset", 64'(wb_data), 64'd0);

    issue(OP_MUL,   32'd7,        32'hFFFF_FFFD, "R2 signed mul", 1'b0);
    issue(OP_MULU,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 unsigned mul", 1'b0);
    issue(OP_MUL,   32'h8000_0000, 32'h8000_0000, "R2 min*min", 1'b0);
    issue(OP_MULR,  32'h1234_5678, 32'hFFFF_FFFF, "R4 mulr", 1'b0);
    issue(OP_MAC,   32'd1000,      32'hFFFF_FF00, "R3 signed mac", 1'b0);
    issue(OP_MULU,  32'hFFFF_FFFF, 32'd1,         "R2 setup", 1'b0);
    issue(OP_MACU,  32'hFFFF_FFFF, 32'h0000_0010, "R3 mac carry", 1'b0);
    issue(OP_MACR,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 macr", 1'b0);
    issue(OP_MACRU, 32'h8000_0001, 32'd3,         "R4 macru", 1'b0);
    issue(OP_MULRU, 32'hABCD_0000, 32'h0001_0000, "R4 mulru", 1'b0);
    issue(OP_DIVU,  32'd100,       32'd7,         "R5 divu", 1'b0);
    issue(OP_DIVU,  32'hFFFF_FFFF, 32'd1,         "R5 divu by one", 1'b0);
    issue(OP_DIV,   32'hFFFF_FFF9, 32'd2,         "R6 neg/pos", 1'b0);
    issue(OP_DIV,   32'd7,         32'hFFFF_FFFE, "R6 pos/neg", 1'b0);
    issue(OP_DIV,   32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6 neg/neg", 1'b0);
    issue(OP_DIV,   32'h8000_0000, 32'hFFFF_FFFF, "R7 min/-1", 1'b0);
    issue(OP_DIV,   32'd55,        32'd0,         "R8 signed div by zero", 1'b0);
    issue(OP_DIVU,  32'd9,         32'd0,         "R8 unsigned div by zero", 1'b0);
    issue(OP_DIVU,  32'd9,         32'd4,         "R8 flag clears", 1'b0);
    issue(OP_DIV,   32'h7FFF_FFFF, 32'd3,         "R9 start while busy", 1'b1);
    issue(OP_MUL,   32'd3,         32'd5,         "R10 after busy", 1'b0);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule